// File: doc/BRIEF.md
# Skewed-Column Ping-Pong Accumulator

This block gathers the results of a two-column systolic matrix unit. The unit emits its columns on a diagonal: the column-0 value for a result appears one cycle before the column-1 value for the same result. The block holds the early column for one cycle, so the two values line up. Each value is widened to 32 bits by zero extension. The aligned pair is then written into one of two storage banks.

Every write either replaces the stored entry or adds the new value to it. Both choices are made per pair, by a mode input and a bank-select input. The updated pair appears on two 32-bit outputs together with a one-cycle valid strobe. While software or a sequencer fills one bank, the other bank keeps its contents for later use. Pairs may stream back to back, one result per cycle.

Top module: `sacc_top`

## Requirements
- R1: A synchronous active-high reset clears both banks, the alignment stage, both sum outputs (to zero) and the valid output. A later accumulate into either bank returns just the new values.
- R2: A column-0 value in cycle T followed by a column-1 value in cycle T+1 produces exactly one `sum_vld` pulse in cycle T+2. That pulse carries the column-0 result on `sum0` and the column-1 result on `sum1`.
- R3: A column-1 value with no column-0 value in the cycle before it is dropped. No valid pulse follows and neither bank changes. A column-0 value with no column-1 value in the next cycle is also dropped.
- R4: `acc_en` and `bank_sel` are sampled in the cycle the column-1 value arrives. With `acc_en`=0 the entry is overwritten with the new value. With `acc_en`=1 the new value is added to the stored entry.
- R5: The 16-bit inputs are zero-extended. After an overwrite, bits 31:16 of each sum are 0 and bits 15:0 equal the input.
- R6: `bank_sel`=0 addresses bank 0 and `bank_sel`=1 addresses bank 1. A write to one bank leaves the other bank unchanged.
- R7: Accumulation wraps modulo 2^32, with no saturation.
- R8: The column-0 value of the next pair may arrive in the same cycle as the column-1 value of the current pair. This gives one result per cycle.
- R9: While `sum_vld` is low, `sum0` and `sum1` keep the last emitted values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c0_vld | input | 1 | Column-0 value present |
| c0_dat | input | 16 | Column-0 partial sum |
| c1_vld | input | 1 | Column-1 value present (one cycle after its column-0 partner) |
| c1_dat | input | 16 | Column-1 partial sum |
| acc_en | input | 1 | 1 = add to stored entry, 0 = overwrite; sampled with column 1 |
| bank_sel | input | 1 | Bank written by the pair; sampled with column 1 |
| sum0 | output | 32 | Updated column-0 entry |
| sum1 | output | 32 | Updated column-1 entry |
| sum_vld | output | 1 | One-cycle strobe marking a new sum pair |

## Verification
Some properties are checked on every cycle by assertions:
- a valid pulse always has a column-1 arrival one cycle back and a column-0 arrival two cycles back;
- an overwrite returns the zero-extended inputs;
- two consecutive accumulates into the same bank differ by exactly the widened new value;
- a bank not addressed by a write stays stable;
- the sums hold while no pair is written;
- reset leaves the outputs cleared.

Other behaviour depends on long histories, so only the bench's scenarios can show it:
- the contents of a bank after interleaved writes to the other bank;
- wrap-around after tens of thousands of accumulations;
- that an orphan column-1 value left no trace in storage;
- that a mid-run reset really empties both banks.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    localparam int COL_N  = 2;
    localparam int IN_W   = 16;
    localparam int ACC_W  = 32;
    localparam int BANKS  = 2;
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int PAD_W  = ACC_W - IN_W;

    typedef logic [IN_W-1:0]  raw_t;
    typedef logic [ACC_W-1:0] acc_t;

    typedef enum logic {
        WM_REPLACE = 1'b0,
        WM_ADD     = 1'b1
    } wmode_e;

    typedef struct packed {
        logic                   vld;
        wmode_e                 mode;
        logic [BANK_W-1:0]      bank;
        logic [COL_N-1:0][IN_W-1:0] raw;
    } wreq_t;

    function automatic acc_t widen(input raw_t v);
        return {{PAD_W{1'b0}}, v};
    endfunction

    function automatic acc_t merge(input wmode_e m, input acc_t base, input raw_t v);
        return (m == WM_ADD) ? (base + widen(v)) : widen(v);
    endfunction

endpackage

// File: rtl/sacc_deskew.sv
module sacc_deskew
    import sacc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [COL_N-1:0]         col_vld,
    input  logic [COL_N-1:0][IN_W-1:0] col_dat,
    input  wmode_e                   mode,
    input  logic [BANK_W-1:0]        bank,
    output wreq_t                    req
);

    logic [COL_N-1:0]            tail_vld;
    logic [COL_N-1:0][IN_W-1:0]  tail_dat;

    for (genvar c = 0; c < COL_N; c++) begin : g_col
        localparam int DLY = COL_N - 1 - c;
        if (DLY == 0) begin : g_direct
            assign tail_vld[c] = col_vld[c];
            assign tail_dat[c] = col_dat[c];
        end else begin : g_hold
            logic [DLY-1:0] v_q;
            raw_t           d_q [DLY];
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= '0;
                    for (int k = 0; k < DLY; k++) d_q[k] <= '0;
                end else begin
                    v_q[0] <= col_vld[c];
                    if (col_vld[c]) d_q[0] <= col_dat[c];
                    for (int k = 1; k < DLY; k++) begin
                        v_q[k] <= v_q[k-1];
                        d_q[k] <= d_q[k-1];
                    end
                end
            end
            assign tail_vld[c] = v_q[DLY-1];
            assign tail_dat[c] = d_q[DLY-1];
        end
    end

    always_comb begin
        req.vld  = &tail_vld;
        req.mode = mode;
        req.bank = bank;
        req.raw  = tail_dat;
    end

    AST_PAIR_NEEDS_LEAD: assert property (@(posedge clk) disable iff (rst)
        req.vld |-> $past(col_vld[0], COL_N - 1)); // R3

endmodule

// File: rtl/sacc_lane.sv
module sacc_lane
    import sacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  wmode_e            mode,
    input  logic [BANK_W-1:0] bank,
    input  raw_t              raw,
    output acc_t              sum
);

    acc_t mem [BANKS];
    acc_t base;
    acc_t nxt;

    always_comb begin
        base = mem[bank];
        nxt  = merge(mode, base, raw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BANKS; b++) mem[b] <= '0;
            sum <= '0;
        end else if (wr) begin
            mem[bank] <= nxt;
            sum       <= nxt;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_iso
        AST_BANK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            !(wr && (bank == BANK_W'(b))) |=> $stable(mem[b])); // R6
    end

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(sum)); // R9

endmodule

// File: rtl/sacc_top.sv
module sacc_top
    import sacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              c0_vld,
    input  logic [IN_W-1:0]   c0_dat,
    input  logic              c1_vld,
    input  logic [IN_W-1:0]   c1_dat,
    input  logic              acc_en,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [ACC_W-1:0]  sum0,
    output logic [ACC_W-1:0]  sum1,
    output logic              sum_vld
);

    logic [COL_N-1:0]            col_vld;
    logic [COL_N-1:0][IN_W-1:0]  col_dat;
    wmode_e                      mode;
    wreq_t                       req;
    acc_t                        lane_sum [COL_N];

    assign col_vld = {c1_vld, c0_vld};
    assign col_dat = {c1_dat, c0_dat};
    assign mode    = acc_en ? WM_ADD : WM_REPLACE;

    sacc_deskew u_deskew (
        .clk     (clk),
        .rst     (rst),
        .col_vld (col_vld),
        .col_dat (col_dat),
        .mode    (mode),
        .bank    (bank_sel),
        .req     (req)
    );

    for (genvar c = 0; c < COL_N; c++) begin : g_lane
        sacc_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .wr   (req.vld),
            .mode (req.mode),
            .bank (req.bank),
            .raw  (req.raw[c]),
            .sum  (lane_sum[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) sum_vld <= 1'b0;
        else     sum_vld <= req.vld;
    end

    assign sum0 = lane_sum[0];
    assign sum1 = lane_sum[1];

    AST_VLD_AFTER_COL1: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> $past(c1_vld)); // R2

    AST_VLD_AFTER_COL0: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> $past(c0_vld, 2)); // R2

    AST_OVERWRITE_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (sum_vld && !$past(acc_en)) |->
            (sum0 == widen($past(c0_dat, 2)) && sum1 == widen($past(c1_dat)))); // R5

    AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (rst)
        (sum_vld && $past(acc_en) && $past(sum_vld) &&
         ($past(bank_sel) == $past(bank_sel, 2))) |->
            (sum0 == $past(sum0) + widen($past(c0_dat, 2)) &&
             sum1 == $past(sum1) + widen($past(c1_dat)))); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!sum_vld && sum0 == '0 && sum1 == '0)); // R1

endmodule

// File: tb/sacc_top_bench.sv
module sacc_top_bench;
    import sacc_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        c0_vld, c1_vld, acc_en;
    logic [15:0] c0_dat, c1_dat;
    logic [0:0]  bank_sel;
    logic [31:0] sum0, sum1;
    logic        sum_vld;

    always #2.5ns clk = ~clk;

    sacc_top u_sacc_top (
        .clk(clk), .rst(rst),
        .c0_vld(c0_vld), .c0_dat(c0_dat),
        .c1_vld(c1_vld), .c1_dat(c1_dat),
        .acc_en(acc_en), .bank_sel(bank_sel),
        .sum0(sum0), .sum1(sum1), .sum_vld(sum_vld)
    );

    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;
    string       cur_tag = "R1";
    logic [31:0] mb [2][2];
    logic        pv0;
    logic [15:0] pd0;
    logic        exp_vld;
    logic [31:0] exp0, exp1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 2; c++) mb[b][c] = '0;
        pv0 = 0; pd0 = '0; exp_vld = 0; exp0 = '0; exp1 = '0;
    endtask

    task automatic cyc(input logic v0, input logic [15:0] d0,
                       input logic v1, input logic [15:0] d1,
                       input logic ac, input logic bk);
        @(negedge clk);
        chk({cur_tag, " valid"}, {31'b0, sum_vld}, {31'b0, exp_vld});
        if (exp_vld) begin
            chk({cur_tag, " sum0"}, sum0, exp0);
            chk({cur_tag, " sum1"}, sum1, exp1);
        end else begin
            chk("R9 sum0 hold", sum0, exp0);
            chk("R9 sum1 hold", sum1, exp1);
        end
        c0_vld = v0; c0_dat = d0; c1_vld = v1; c1_dat = d1;
        acc_en = ac; bank_sel = bk;
        if (v1 && pv0) begin
            logic [31:0] w0, w1;
            w0 = {16'b0, pd0};
            w1 = {16'b0, d1};
            mb[bk][0] = ac ? mb[bk][0] + w0 : w0;
            mb[bk][1] = ac ? mb[bk][1] + w1 : w1;
            exp0 = mb[bk][0];
            exp1 = mb[bk][1];
            exp_vld = 1;
        end else begin
            exp_vld = 0;
        end
        pv0 = v0;
        if (v0) pd0 = d0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; c0_vld = 0; c1_vld = 0; c0_dat = '0; c1_dat = '0;
        acc_en = 0; bank_sel = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        clear_model();
    endtask

    task automatic idle();
        cyc(0, '0, 0, '0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; c0_vld = 0; c1_vld = 0; c0_dat = '0; c1_dat = '0;
        acc_en = 0; bank_sel = 0;
        clear_model();
        do_reset();

        // R1: reset state
        cur_tag = "R1";
        idle();
        chk("R1 sum0 zero", sum0, 32'h0);
        chk("R1 sum1 zero", sum1, 32'h0);

        // R2/R4: isolated pairs across all mode/bank combinations
        cur_tag = "R4";
        for (int bk = 0; bk < 2; bk++)
            for (int ac = 0; ac < 2; ac++)
                for (int i = 0; i < 24; i++) begin
                    logic [15:0] a, b;
                    a = 16'(i * 16'h0AF1 + bk * 7 + ac * 3);
                    b = ~a ^ 16'(i);
                    cyc(1, a, 0, '0, 0, 0);
                    cyc(0, '0, 1, b, ac[0], bk[0]);
                    idle();
                end

        // R3: orphan column 0, then column 1 two cycles later
        cur_tag = "R3";
        cyc(1, 16'd5, 0, '0, 0, 0);
        idle();
        cyc(0, '0, 1, 16'd9, 1, 0);
        idle();
        // R3: orphan column 1 after idle, then prove banks unchanged
        cyc(0, '0, 1, 16'd77, 1, 1);
        cyc(0, '0, 1, 16'd88, 1, 0);
        idle();
        cyc(1, '0, 0, '0, 0, 0);
        cyc(0, '0, 1, '0, 1, 1);
        cyc(1, '0, 0, '0, 0, 0);
        cyc(0, '0, 1, '0, 1, 0);
        idle();

        // R6: bank isolation
        cur_tag = "R6";
        cyc(1, 16'd10, 0, '0, 0, 0);
        cyc(1, 16'd30, 1, 16'd20, 0, 0);
        cyc(1, 16'd1,  1, 16'd40, 0, 1);
        cyc(0, '0,     1, 16'd1,  1, 0);
        idle();
        chk("R6 bank0 col0", sum0, 32'd11);
        chk("R6 bank0 col1", sum1, 32'd21);

        // R8: back-to-back streaming
        cur_tag = "R8";
        begin
            logic [15:0] prev_b;
            prev_b = '0;
            for (int k = 0; k < 64; k++) begin
                logic [15:0] a, b;
                a = 16'(k * 16'h3C5 + 16'h11);
                b = 16'(k * 16'h713 ^ 16'h5A5A);
                cyc(1, a, (k > 0), prev_b, ((k % 3) != 0), k[0]);
                prev_b = b;
            end
            cyc(0, '0, 1, prev_b, 1, 1);
            idle();
        end

        // R5: zero extension
        cur_tag = "R5";
        cyc(1, 16'hFFFF, 0, '0, 0, 0);
        cyc(0, '0, 1, 16'h8000, 0, 1);
        idle();
        chk("R5 upper zero col0", sum0, 32'h0000_FFFF);
        chk("R5 upper zero col1", sum1, 32'h0000_8000);

        // R7: wrap modulo 2^32 after 65538 accumulations
        cur_tag = "R7";
        cyc(1, 16'hFFFF, 0, '0, 0, 0);
        cyc(1, 16'hFFFF, 1, 16'hFFFF, 0, 1);
        for (int n = 0; n < 65537; n++)
            cyc(1, 16'hFFFF, 1, 16'hFFFF, 1, 1);
        cyc(0, '0, 1, 16'hFFFF, 1, 1);
        idle();
        chk("R7 wrap col0", sum0, 32'h0001_FFFD);
        chk("R7 wrap col1", sum1, 32'h0001_FFFD);

        // R1: mid-run reset clears both banks
        do_reset();
        cur_tag = "R1";
        idle();
        cyc(1, 16'd3, 0, '0, 0, 0);
        cyc(0, '0, 1, 16'd4, 1, 1);
        cyc(1, 16'd6, 0, '0, 0, 0);
        cyc(0, '0, 1, 16'd8, 1, 0);
        idle();
        chk("R1 bank0 after reset col0", sum0, 32'd6);
        chk("R1 bank0 after reset col1", sum1, 32'd8);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule